// File: doc/BRIEF.md
# Reduced-Precision Floating-Point Adder

This block adds or subtracts two floating-point numbers whose exponent and fraction widths are chosen per instance. Each operand is one word laid out as sign, biased exponent and fraction. The top bit is the sign, the next `EXP_W` bits are the exponent, and the low `MAN_W` bits are the fraction, with a hidden leading one. A strobe marks a valid operand pair, and the block takes a new pair on every clock. The result leaves after a fixed number of cycles, together with its own strobe.

The datapath runs in five steps:

1. It ranks the operands by magnitude and swaps them so the larger one comes first.
2. It shifts the smaller fraction right to line it up with the larger one.
3. It adds or subtracts the two fractions.
4. It counts the leading zeros of the raw sum.
5. It shifts the sum back into normal form and adjusts the exponent.

The `STAGE_SEL` parameter decides which of three boundaries between these steps gets a register. This lets an integrator trade latency against logic depth.

The block trades accuracy for area and speed:

- Denormal operands count as zero.
- A result too small to be normal becomes zero.
- Bits that fall below the kept precision are discarded, with no rounding.
- NaN and infinity pass through to the output and never turn into finite numbers.

Top module: `fpadd_top`

## Requirements
- R1: With `op_sub`=0 the result is opnd_a+opnd_b, and with `op_sub`=1 it is opnd_a−opnd_b; subtraction is done by inverting the sign of opnd_b. Word layout: bit `EXP_W+MAN_W` is the sign, bits `[EXP_W+MAN_W-1:MAN_W]` are the biased exponent, and bits `[MAN_W-1:0]` are the fraction.
- R2: An operand whose exponent field is 0 counts as zero, whatever its fraction.
- R3: A sum that is exactly zero, or whose exponent after normalization is 0 or below, is output as all zeros (+0).
- R4: During alignment the smaller operand keeps `GUARD` bits below the fraction; bits shifted out beyond them are lost. A shift distance of `MAN_W+1+GUARD` or more makes the smaller operand zero. The normalized fraction is truncated, not rounded.
- R5: If either operand is a NaN (exponent all ones, fraction non-zero), the result is the canonical NaN: sign 0, exponent all ones, fraction with only its top bit set.
- R6: Two infinities with opposite effective signs give the canonical NaN. Two infinities with the same sign give that infinity. An infinity and a finite value give the infinity, with its effective sign.
- R7: A normalized exponent of all ones or above gives infinity (fraction 0) with the sign of the result.
- R8: One operand pair can be accepted on every clock. Back-to-back pairs all produce results, in order.
- R9: `out_valid` follows `in_valid` delayed by the number of set bits in `STAGE_SEL` (3 by default), and it is 0 during reset.
- R10: A finite non-zero result takes the sign of the operand with the larger magnitude. Magnitude is compared on exponent and then fraction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized inside the block |
| in_valid | input | 1 | Operand pair valid |
| op_sub | input | 1 | 1 = subtract opnd_b from opnd_a |
| opnd_a | input | 1+EXP_W+MAN_W | First operand |
| opnd_b | input | 1+EXP_W+MAN_W | Second operand |
| out_valid | output | 1 | Result valid |
| result | output | 1+EXP_W+MAN_W | Sum or difference |

## Verification
The directed cases cover the following, with the failure each one exposes:

- Equal operands that cancel: a missing zero test would produce a garbage exponent.
- A carry out of the top fraction bit: a wrong exponent adjustment would halve or double the value.
- Differences that fall below the smallest normal: these must flush and must not wrap the exponent.
- Sums of the largest values: these must saturate to infinity, not wrap to a small number.
- Alignment distances one bit beyond the kept precision: an off-by-one in the guard handling would change the low fraction bit.

The special-value cases target the failures below:

- Infinity minus infinity: a wrong sign test would return infinity instead of NaN.
- A NaN operand beside an infinity: the wrong priority would let the infinity win.
- Denormal operands: a design that forgets the flush would let their fraction leak into the sum.

Random traffic with close exponents drives heavy cancellation through the leading-zero path. A single isolated operand pair pins down the latency.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;

  typedef enum logic [1:0] {
    KIND_ZERO,
    KIND_NUM,
    KIND_INF,
    KIND_NAN
  } fp_kind_e;

  // Sort an operand into its class from three field tests.
  function automatic fp_kind_e kind_of(input logic exp_zero, input logic exp_full,
                                       input logic frac_nz);
    if (exp_full) return frac_nz ? KIND_NAN : KIND_INF;
    if (exp_zero) return KIND_ZERO;
    return KIND_NUM;
  endfunction

endpackage

// File: rtl/fpadd_pipe.sv
module fpadd_pipe #(
  parameter int DW = 8,
  parameter bit EN = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          v_in,
  input  logic [DW-1:0] d_in,
  output logic          v_out,
  output logic [DW-1:0] d_out
);

  generate
    if (EN) begin : g_reg
      logic          v_q;
      logic [DW-1:0] d_q, d_nxt;

      always_comb d_nxt = v_in ? d_in : d_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) v_q <= 1'b0;
        else        v_q <= v_in;
      end

      always_ff @(posedge clk) d_q <= d_nxt;

      assign v_out = v_q;
      assign d_out = d_q;
    end else begin : g_wire
      assign v_out = v_in;
      assign d_out = d_in;
    end
  endgenerate

endmodule

// File: rtl/fpadd_align.sv
module fpadd_align
  import fpadd_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 10,
  parameter int GUARD = 2,
  localparam int W     = 1 + EXP_W + MAN_W,
  localparam int WW    = MAN_W + 1 + GUARD,
  localparam int OUT_W = 1 + W + 1 + 1 + EXP_W + 2 * WW
) (
  input  logic [W-1:0]     opnd_a,
  input  logic [W-1:0]     opnd_b,
  input  logic             op_sub,
  output logic [OUT_W-1:0] pkt
);

  localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};
  localparam logic [EXP_W-1:0] WW_E = EXP_W'(WW);

  logic             sa, sb, a_big, nan_any, inf_any;
  logic [EXP_W-1:0] ea, eb, big_e, sml_e, diff;
  logic [MAN_W:0]   ma, mb, big_m, sml_m;
  logic [WW-1:0]    sml_sh;
  logic [W-1:0]     spec_res;
  fp_kind_e         ka, kb;

  always_comb begin
    sa = opnd_a[W-1];
    sb = opnd_b[W-1] ^ op_sub;
    ka = kind_of(opnd_a[W-2 -: EXP_W] == '0, opnd_a[W-2 -: EXP_W] == '1,
                 opnd_a[MAN_W-1:0] != '0);
    kb = kind_of(opnd_b[W-2 -: EXP_W] == '0, opnd_b[W-2 -: EXP_W] == '1,
                 opnd_b[MAN_W-1:0] != '0);
    // flushed operands become exact zero before ranking
    ea = (ka == KIND_NUM) ? opnd_a[W-2 -: EXP_W] : '0;
    eb = (kb == KIND_NUM) ? opnd_b[W-2 -: EXP_W] : '0;
    ma = (ka == KIND_NUM) ? {1'b1, opnd_a[MAN_W-1:0]} : '0;
    mb = (kb == KIND_NUM) ? {1'b1, opnd_b[MAN_W-1:0]} : '0;

    a_big = {ea, ma} >= {eb, mb};
    big_e = a_big ? ea : eb;
    sml_e = a_big ? eb : ea;
    big_m = a_big ? ma : mb;
    sml_m = a_big ? mb : ma;
    diff  = big_e - sml_e;
    sml_sh = (diff >= WW_E) ? '0 : ({sml_m, {GUARD{1'b0}}} >> diff);

    inf_any = (ka == KIND_INF) || (kb == KIND_INF);
    nan_any = (ka == KIND_NAN) || (kb == KIND_NAN) ||
              ((ka == KIND_INF) && (kb == KIND_INF) && (sa != sb));
    spec_res = nan_any ? QNAN
                       : {((ka == KIND_INF) ? sa : sb), {EXP_W{1'b1}}, {MAN_W{1'b0}}};

    pkt = {nan_any | inf_any, spec_res, (a_big ? sa : sb), (sa != sb), big_e,
           {big_m, {GUARD{1'b0}}}, sml_sh};
  end

endmodule

// File: rtl/fpadd_addsub.sv
module fpadd_addsub #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 10,
  parameter int GUARD = 2,
  localparam int W     = 1 + EXP_W + MAN_W,
  localparam int WW    = MAN_W + 1 + GUARD,
  localparam int IN_W  = 1 + W + 1 + 1 + EXP_W + 2 * WW,
  localparam int OUT_W = 1 + W + 1 + EXP_W + WW + 1
) (
  input  logic [IN_W-1:0]  pkt_in,
  output logic [OUT_W-1:0] pkt_out
);

  logic             spec, sgn, eff_sub;
  logic [W-1:0]     sres;
  logic [EXP_W-1:0] bexp;
  logic [WW-1:0]    bm, sm;
  logic [WW:0]      sum;

  always_comb begin
    {spec, sres, sgn, eff_sub, bexp, bm, sm} = pkt_in;
    // big >= small in magnitude, so the difference never goes negative
    sum = eff_sub ? ({1'b0, bm} - {1'b0, sm}) : ({1'b0, bm} + {1'b0, sm});
    pkt_out = {spec, sres, sgn, bexp, sum};
  end

endmodule

// File: rtl/fpadd_norm.sv
module fpadd_norm #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 10,
  parameter int GUARD = 2,
  localparam int W    = 1 + EXP_W + MAN_W,
  localparam int WW   = MAN_W + 1 + GUARD,
  localparam int IN_W = 1 + W + 1 + EXP_W + WW + 1,
  localparam int LZ_W = $clog2(WW + 2),
  localparam int EW   = EXP_W + 2,
  localparam int EMAX = (1 << EXP_W) - 1
) (
  input  logic [IN_W-1:0] pkt_in,
  output logic [W-1:0]    res
);

  logic                 spec, sgn, found;
  logic [W-1:0]         sres;
  logic [EXP_W-1:0]     bexp;
  logic [WW:0]          sum, shifted;
  logic [LZ_W-1:0]      lz;
  logic signed [EW-1:0] e_wide;

  always_comb begin
    {spec, sres, sgn, bexp, sum} = pkt_in;
    found = 1'b0;
    lz    = '0;
    for (int i = WW; i >= 0; i--) begin
      if (!found && sum[i]) begin
        found = 1'b1;
        lz    = LZ_W'(WW - i);
      end
    end
    shifted = sum << lz;
    e_wide  = $signed({2'b00, bexp}) + $signed(EW'(1)) - $signed(EW'(lz));

    if (spec)                                res = sres;
    else if (!found || e_wide <= 0)          res = '0;
    else if (e_wide >= $signed(EW'(EMAX)))   res = {sgn, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
    else res = {sgn, e_wide[EXP_W-1:0], shifted[WW-1 -: MAN_W]};
  end

endmodule

// File: rtl/fpadd_top.sv
module fpadd_top #(
  parameter int         EXP_W     = 8,
  parameter int         MAN_W     = 10,
  parameter int         GUARD     = 2,
  parameter logic [2:0] STAGE_SEL = 3'b111,
  localparam int W    = 1 + EXP_W + MAN_W,
  localparam int WW   = MAN_W + 1 + GUARD,
  localparam int A_W  = 1 + W + 1 + 1 + EXP_W + 2 * WW,
  localparam int S_W  = 1 + W + 1 + EXP_W + WW + 1,
  localparam int LAT  = int'(STAGE_SEL[0]) + int'(STAGE_SEL[1]) + int'(STAGE_SEL[2])
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic         op_sub,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  output logic         out_valid,
  output logic [W-1:0] result
);

  logic [1:0]     rsync;
  logic           rst_sync_n;
  logic           v1, v2;
  logic [A_W-1:0] a_pkt, a_pkt_q;
  logic [S_W-1:0] s_pkt, s_pkt_q;
  logic [W-1:0]   n_res;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= 2'b00;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign rst_sync_n = rsync[1];

  fpadd_align #(.EXP_W(EXP_W), .MAN_W(MAN_W), .GUARD(GUARD)) u_align (
    .opnd_a(opnd_a), .opnd_b(opnd_b), .op_sub(op_sub), .pkt(a_pkt));

  fpadd_pipe #(.DW(A_W), .EN(STAGE_SEL[0])) u_p0 (
    .clk(clk), .rst_n(rst_sync_n), .v_in(in_valid), .d_in(a_pkt),
    .v_out(v1), .d_out(a_pkt_q));

  fpadd_addsub #(.EXP_W(EXP_W), .MAN_W(MAN_W), .GUARD(GUARD)) u_addsub (
    .pkt_in(a_pkt_q), .pkt_out(s_pkt));

  fpadd_pipe #(.DW(S_W), .EN(STAGE_SEL[1])) u_p1 (
    .clk(clk), .rst_n(rst_sync_n), .v_in(v1), .d_in(s_pkt),
    .v_out(v2), .d_out(s_pkt_q));

  fpadd_norm #(.EXP_W(EXP_W), .MAN_W(MAN_W), .GUARD(GUARD)) u_norm (
    .pkt_in(s_pkt_q), .res(n_res));

  fpadd_pipe #(.DW(W), .EN(STAGE_SEL[2])) u_p2 (
    .clk(clk), .rst_n(rst_sync_n), .v_in(v2), .d_in(n_res),
    .v_out(out_valid), .d_out(result));

endmodule

// File: rtl/fpadd_chk.sv
module fpadd_chk #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 10,
  parameter int LAT   = 3,
  localparam int W    = 1 + EXP_W + MAN_W
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         op_sub,
  input logic [W-1:0] opnd_a,
  input logic [W-1:0] opnd_b,
  input logic         out_valid,
  input logic [W-1:0] result
);

  localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  logic a_nan, b_nan, a_inf, b_inf;
  logic [LAT:0] v_d, nan_d, cxl_d;

  assign a_nan = (opnd_a[W-2 -: EXP_W] == '1) && (opnd_a[MAN_W-1:0] != '0);
  assign b_nan = (opnd_b[W-2 -: EXP_W] == '1) && (opnd_b[MAN_W-1:0] != '0);
  assign a_inf = (opnd_a[W-2 -: EXP_W] == '1) && (opnd_a[MAN_W-1:0] == '0);
  assign b_inf = (opnd_b[W-2 -: EXP_W] == '1) && (opnd_b[MAN_W-1:0] == '0);

  assign v_d[0]   = in_valid;
  assign nan_d[0] = in_valid && (a_nan || b_nan);
  assign cxl_d[0] = in_valid && a_inf && b_inf && (opnd_a[W-1] != (opnd_b[W-1] ^ op_sub));

  for (genvar i = 1; i <= LAT; i++) begin : g_dly
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_d[i]   <= 1'b0;
        nan_d[i] <= 1'b0;
        cxl_d[i] <= 1'b0;
      end else begin
        v_d[i]   <= v_d[i-1];
        nan_d[i] <= nan_d[i-1];
        cxl_d[i] <= cxl_d[i-1];
      end
    end
  end

  // R9
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == v_d[LAT]);

  // R5
  nan_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && nan_d[LAT]) |-> (result == QNAN));

  // R6
  inf_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cxl_d[LAT]) |-> (result == QNAN));

  // R3
  no_denorm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (result[W-2 -: EXP_W] == '0)) |-> (result == '0));

endmodule

bind fpadd_top fpadd_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W), .LAT(LAT)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .in_valid(in_valid), .op_sub(op_sub),
  .opnd_a(opnd_a), .opnd_b(opnd_b), .out_valid(out_valid), .result(result));

// File: tb/tb_fpadd_top.sv
`timescale 1ns/1ps
module tb_fpadd_top;

  localparam int EXP_W = 8;
  localparam int MAN_W = 10;
  localparam int GUARD = 2;
  localparam int W     = 1 + EXP_W + MAN_W;
  localparam int WW    = MAN_W + 1 + GUARD;
  localparam int EMAX  = (1 << EXP_W) - 1;
  localparam int LAT   = 3;
  localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  logic         clk, rst_n, in_valid, op_sub, out_valid;
  logic [W-1:0] opnd_a, opnd_b, result;

  int n_chk = 0, n_fail = 0, n_in = 0, n_out = 0;
  logic [W-1:0] exp_q[$];
  string        tag_q[$];

  fpadd_top #(.EXP_W(EXP_W), .MAN_W(MAN_W), .GUARD(GUARD), .STAGE_SEL(3'b111)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sub(op_sub),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .out_valid(out_valid), .result(result));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [W-1:0] mk(input logic s, input int e, input int f);
    return {s, EXP_W'(e), MAN_W'(f)};
  endfunction

  // Expected sum built from the requirement text.
  function automatic logic [W-1:0] ref_sum(input logic [W-1:0] a, input logic [W-1:0] b,
                                           input logic sub);
    logic sa, sb, st;
    int ea, eb, d, p, e, ti;
    longint fa, fb, x, y, xx, yy, s, t;
    sa = a[W-1];          sb = b[W-1] ^ sub;
    ea = int'(a[W-2 -: EXP_W]); eb = int'(b[W-2 -: EXP_W]);
    fa = longint'(a[MAN_W-1:0]); fb = longint'(b[MAN_W-1:0]);
    if ((ea == EMAX && fa != 0) || (eb == EMAX && fb != 0)) return QNAN;
    if (ea == EMAX && eb == EMAX) return (sa != sb) ? QNAN : mk(sa, EMAX, 0);
    if (ea == EMAX) return mk(sa, EMAX, 0);
    if (eb == EMAX) return mk(sb, EMAX, 0);
    x = (ea == 0) ? 0 : ((longint'(1) << MAN_W) | fa);
    y = (eb == 0) ? 0 : ((longint'(1) << MAN_W) | fb);
    if (ea < eb || (ea == eb && x < y)) begin
      t = x; x = y; y = t; ti = ea; ea = eb; eb = ti; st = sa; sa = sb; sb = st;
    end
    d  = ea - eb;
    xx = x << GUARD;
    yy = (d >= WW) ? 0 : ((y << GUARD) >> d);
    s  = (sa == sb) ? xx + yy : xx - yy;
    if (s == 0) return '0;
    p = 0;
    for (int i = 0; i <= WW; i++) if (((s >> i) & 1) != 0) p = i;
    e = ea + p - (WW - 1);
    if (e <= 0) return '0;
    if (e >= EMAX) return mk(sa, EMAX, 0);
    return mk(sa, e, int'(((s << (WW - p)) >> (WW - MAN_W)) & ((1 << MAN_W) - 1)));
  endfunction

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic send(input logic [W-1:0] a, input logic [W-1:0] b, input logic sub,
                      input logic [W-1:0] expv, input string tag);
    @(negedge clk);
    opnd_a = a; opnd_b = b; op_sub = sub; in_valid = 1'b1;
    exp_q.push_back(expv);
    tag_q.push_back(tag);
    n_in++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  function automatic logic [W-1:0] rnd_op(input int base);
    int k, e;
    k = int'($urandom_range(0, 15));
    if (k == 0)      e = EMAX;
    else if (k == 1) e = 0;
    else if (k == 2) e = int'($urandom_range(EMAX - 5, EMAX - 1));
    else if (k == 3) e = int'($urandom_range(1, 4));
    else begin
      e = base + int'($urandom_range(0, 4)) - 2;
      if (e < 1) e = 1;
      if (e > EMAX - 1) e = EMAX - 1;
    end
    if (k == 0 && $urandom_range(0, 1) == 0) return mk($urandom_range(0, 1) == 1, e, 0);
    return mk($urandom_range(0, 1) == 1, e, int'($urandom_range(0, (1 << MAN_W) - 1)));
  endfunction

  // output monitor
  always @(posedge clk) begin
    #1;
    if (out_valid === 1'b1) begin
      n_out++;
      if (exp_q.size() == 0) check(1'b0, "R9 unexpected out_valid", result, '0);
      else begin
        logic [W-1:0] ev;
        string        tg;
        ev = exp_q.pop_front();
        tg = tag_q.pop_front();
        check(result === ev, tg, result, ev);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [W-1:0] a, b;
    logic         s;
    int           k, base, seen;
    void'($urandom(32'd4711));
    rst_n = 1'b0; in_valid = 1'b0; op_sub = 1'b0; opnd_a = '0; opnd_b = '0;
    repeat (4) @(posedge clk);
    #1 check(out_valid === 1'b0, "R9 reset out_valid", {{(W-1){1'b0}}, out_valid}, '0);
    @(negedge clk); rst_n = 1'b1;
    idle(4);

    // R1 plain add and subtract
    send(mk(0,127,0), mk(0,127,0), 1'b0, mk(0,128,0), "R1 1+1");
    send(mk(0,128,512), mk(0,127,0), 1'b1, mk(0,128,0), "R1 3-1");
    // R10 sign from larger magnitude
    send(mk(0,127,0), mk(0,128,0), 1'b1, mk(1,127,0), "R10 1-2");
    send(mk(0,128,0), mk(1,127,0), 1'b0, mk(0,127,0), "R10 2+(-1)");
    // R3 exact cancel and underflow
    send(mk(0,127,0), mk(0,127,0), 1'b1, '0, "R3 x-x");
    send(mk(0,1,1), mk(0,1,0), 1'b1, '0, "R3 underflow");
    // R2 denormal operands
    send(mk(0,0,341), mk(0,127,0), 1'b0, mk(0,127,0), "R2 denorm+1");
    send(mk(1,0,5), mk(0,0,900), 1'b0, '0, "R2 denorm+denorm");
    // R4 truncation and alignment limits
    send(mk(0,127,0), mk(0,116,0), 1'b0, mk(0,127,0), "R4 tiny lost");
    send(mk(0,127,0), mk(0,117,0), 1'b0, mk(0,127,1), "R4 lsb kept");
    send(mk(0,127,0), mk(0,115,0), 1'b1, mk(0,126,1023), "R4 sub truncate");
    send(mk(0,147,0), mk(0,127,0), 1'b0, mk(0,147,0), "R4 far shift");
    // R7 overflow
    send(mk(0,254,1023), mk(0,254,1023), 1'b0, mk(0,EMAX,0), "R7 +overflow");
    send(mk(1,254,1023), mk(0,254,1023), 1'b1, mk(1,EMAX,0), "R7 -overflow");
    // R5 NaN
    send(mk(1,EMAX,7), mk(0,127,0), 1'b0, QNAN, "R5 nan+1");
    send(mk(0,EMAX,0), mk(0,EMAX,1), 1'b0, QNAN, "R5 inf+nan");
    // R6 infinities
    send(mk(0,EMAX,0), mk(0,EMAX,0), 1'b1, QNAN, "R6 inf-inf");
    send(mk(0,EMAX,0), mk(1,EMAX,0), 1'b0, QNAN, "R6 inf+(-inf)");
    send(mk(0,EMAX,0), mk(0,EMAX,0), 1'b0, mk(0,EMAX,0), "R6 inf+inf");
    send(mk(0,127,0), mk(0,EMAX,0), 1'b1, mk(1,EMAX,0), "R6 1-inf");
    idle(8);

    // R9 isolated latency
    @(negedge clk);
    opnd_a = mk(0,127,0); opnd_b = mk(0,127,0); op_sub = 1'b0; in_valid = 1'b1;
    exp_q.push_back(mk(0,128,0)); tag_q.push_back("R9 latency value"); n_in++;
    seen = 0;
    for (int c = 1; c <= 8; c++) begin
      @(posedge clk); #1;
      if (c == 1) in_valid = 1'b0;
      if (seen == 0 && out_valid === 1'b1) seen = c;
    end
    check(seen == LAT, "R9 latency cycles", W'(seen), W'(LAT));
    idle(4);

    // R8 back-to-back random burst
    for (int i = 0; i < 2000; i++) begin
      base = int'($urandom_range(1, EMAX - 1));
      a = rnd_op(base); b = rnd_op(base); s = $urandom_range(0, 1) == 1;
      send(a, b, s, ref_sum(a, b, s), "R8 R1 random stream");
    end
    // random with gaps
    for (int i = 0; i < 1000; i++) begin
      k = int'($urandom_range(0, 3));
      if (k == 0) idle(1);
      base = int'($urandom_range(1, EMAX - 1));
      a = rnd_op(base); b = rnd_op(base); s = $urandom_range(0, 1) == 1;
      send(a, b, s, ref_sum(a, b, s), "R1 R10 random gaps");
    end
    idle(10);
    check(n_out == n_in, "R8 result count", W'(n_out), W'(n_in));

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule